// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive byte stream of an Ethernet MAC. It decides, for each incoming frame, whether the frame should be kept and sent on to the receive FIFO. Bytes arrive one per valid beat, with start and end markers. The filter keeps the 48-bit destination address from the first six bytes, and the length/type field from bytes 12 and 13. It then weighs them against a set of programmable match sources. Each bit of a byte arrives least significant first, so byte 0 bit 0 is the first address bit on the wire. That bit is the group (multicast) flag.

The match sources are four specific-address slots, four type-ID slots, a 64-bit hash table, an external match input, a broadcast rule and a promiscuous mode. A frame is refused outright if the MAC is transmitting in half duplex while the last address byte is received. A configuration bit lifts this rule. The verdict comes out as a one-cycle decision pulse, with an accept flag and a match-reason code. The verdict arrives well before the end of any frame that is longer than the header.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: Address bytes 0 to 5 fill the destination address with byte 0 in bits 7:0, so address bit 0 is byte 0 bit 0. A frame of at least 14 bytes gets exactly one `dec_valid` pulse. That pulse comes two clock edges after the edge that samples byte 13, and later bytes do not produce another.
- R2: Specific-address slot k (k = 0..3) is written at address 2k with address bits 31:0, and at address 2k+1 with bits 47:32 in data bits 15:0. Writing 2k+1 enables the slot and writing 2k disables it. An enabled slot whose value equals the destination address is a hit.
- R3: Type-ID slot j is written at address 8+j with the value in bits 15:0 and the enable in bit 31. A hit occurs when an enabled value equals {byte 12, byte 13}.
- R4: The hash index bit i is the XOR of address bits i, i+6, ..., i+42. The table is written at address 12 (bits 31:0) and 13 (bits 63:32). The selected table bit gives a hit only when the matching enable is on: `cfg_mcast_hash_en` if address bit 0 is 1, otherwise `cfg_ucast_hash_en`.
- R5: `ext_match` high at the edge that produces the verdict is a hit.
- R6: An all-ones destination address is a hit unless `cfg_bcast_reject` is set. With the reject bit set, such a frame can still pass through another source.
- R7: With `cfg_promisc` set, every frame of six or more bytes that is not refused under R8 is accepted.
- R8: If `stat_half_duplex` and `stat_tx_active` are both high on the beat carrying byte 5, and `cfg_hdx_rx_en` is low, the frame is rejected with code 0. This holds whatever the other sources say. The status inputs on other beats have no effect.
- R9: `frame_accept` is 1 exactly when `match_code` is non-zero. When several sources hit, the code names the first in this order: 1..4 specific slots 0..3, 5 type-ID, 6 hash, 7 external, 8 broadcast, 9 promiscuous.
- R10: A frame that ends before byte 13 is decided from its end-of-frame beat, with the same two-edge latency, and type-ID is not compared. A frame shorter than six bytes is always rejected with code 0.
- R11: After reset, `dec_valid`, `frame_accept` and `match_code` are 0, and all specific and type-ID slots are disabled with a zero hash table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_reject | input | 1 | Do not accept all-ones addresses on their own |
| cfg_mcast_hash_en | input | 1 | Hash lookup for group addresses |
| cfg_ucast_hash_en | input | 1 | Hash lookup for individual addresses |
| cfg_hdx_rx_en | input | 1 | Allow reception while transmitting in half duplex |
| stat_half_duplex | input | 1 | MAC runs in half duplex |
| stat_tx_active | input | 1 | MAC is transmitting |
| ext_match | input | 1 | External match input |
| reg_wr_en | input | 1 | Match register write strobe |
| reg_wr_addr | input | 4 | Match register address |
| reg_wr_data | input | 32 | Match register write data |
| dec_valid | output | 1 | One-cycle verdict pulse |
| frame_accept | output | 1 | Frame is accepted (held until next verdict) |
| match_code | output | 4 | Reason for the verdict (held until next verdict) |

## Verification
The assertions assume that the configuration inputs stay steady from the start of a frame to its verdict. They also assume that each frame opens with a start marker and that no register write lands between the last header byte and the verdict. The stimulus sets configuration and registers only while the receive side is idle, and it leaves idle gaps between frames. Only the half-duplex status and the external match input change within a frame, as R8 and R5 require.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int SA_COUNT   = 4;
  localparam int TID_COUNT  = 4;
  localparam int DA_BYTES   = 6;
  localparam int DA_W       = DA_BYTES * 8;
  localparam int HDR_BYTES  = 14;
  localparam int TYPE_HI    = 12;
  localparam int TYPE_LO    = 13;
  localparam int HIDX_W     = 6;
  localparam int HASH_W     = 1 << HIDX_W;
  localparam int CODE_W     = 4;
  localparam int CODE_COUNT = 10;

  typedef enum logic [CODE_W-1:0] {
    MC_NONE    = 4'd0,
    MC_SA0     = 4'd1,
    MC_TYPE    = 4'd5,
    MC_HASH    = 4'd6,
    MC_EXT     = 4'd7,
    MC_BCAST   = 4'd8,
    MC_PROMISC = 4'd9
  } match_code_e;

  typedef struct packed {
    logic promisc;
    logic bcast_reject;
    logic mcast_hash;
    logic ucast_hash;
    logic hdx_rx_en;
  } filt_cfg_t;

  // Fold the address into a table index: index bit i collects every sixth bit.
  function automatic logic [HIDX_W-1:0] hash_index(input logic [DA_W-1:0] da);
    logic [HIDX_W-1:0] idx;
    idx = '0;
    for (int b = 0; b < DA_W; b++) begin
      idx[b % HIDX_W] = idx[b % HIDX_W] ^ da[b];
    end
    return idx;
  endfunction

  function automatic logic is_group(input logic [DA_W-1:0] da);
    return da[0];
  endfunction

  function automatic logic is_bcast(input logic [DA_W-1:0] da);
    return &da;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [31:0]                       wr_data,
  output logic [SA_COUNT-1:0][DA_W-1:0]     sa_val,
  output logic [SA_COUNT-1:0]               sa_en,
  output logic [TID_COUNT-1:0][15:0]        tid_val,
  output logic [TID_COUNT-1:0]              tid_en,
  output logic [HASH_W-1:0]                 hash_tbl
);
  localparam int TID_BASE  = 2 * SA_COUNT;
  localparam int HASH_BASE = TID_BASE + TID_COUNT;

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sa_val[k] <= '0;
        sa_en[k]  <= 1'b0;
      end else if (wr_en && wr_addr == A_LO) begin
        sa_val[k][31:0] <= wr_data;
        sa_en[k]        <= 1'b0;
      end else if (wr_en && wr_addr == A_HI) begin
        sa_val[k][DA_W-1:32] <= wr_data[DA_W-33:0];
        sa_en[k]             <= 1'b1;
      end
    end
  end

  for (genvar j = 0; j < TID_COUNT; j++) begin : g_tid
    localparam logic [ADDR_W-1:0] A_T = ADDR_W'(TID_BASE + j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tid_val[j] <= '0;
        tid_en[j]  <= 1'b0;
      end else if (wr_en && wr_addr == A_T) begin
        tid_val[j] <= wr_data[15:0];
        tid_en[j]  <= wr_data[31];
      end
    end
  end

  for (genvar h = 0; h < HASH_W / 32; h++) begin : g_hash
    localparam logic [ADDR_W-1:0] A_H = ADDR_W'(HASH_BASE + h);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hash_tbl[h*32 +: 32] <= '0;
      end else if (wr_en && wr_addr == A_H) begin
        hash_tbl[h*32 +: 32] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_data,
  input  logic            block_now,
  output logic [DA_W-1:0] da,
  output logic [15:0]     typ,
  output logic            da_ok,
  output logic            type_ok,
  output logic            blocked,
  output logic            pend
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] SAT_IDX  = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] DA_LAST  = CNT_W'(DA_BYTES - 1);
  localparam logic [CNT_W-1:0] T_HI     = CNT_W'(TYPE_HI);
  localparam logic [CNT_W-1:0] T_LO     = CNT_W'(TYPE_LO);

  logic [CNT_W-1:0]           cnt_q, idx;
  logic                       done_q, done_eff, trig;
  logic [DA_BYTES-1:0][7:0]   da_q;
  logic [15:0]                typ_q;
  logic                       blocked_q, da_ok_q, type_ok_q, pend_q;

  assign idx      = rx_sof ? '0 : cnt_q;
  assign done_eff = rx_sof ? 1'b0 : done_q;
  assign trig     = rx_valid && !done_eff &&
                    (idx == LAST_IDX || (rx_eof && idx < LAST_IDX));

  for (genvar k = 0; k < DA_BYTES; k++) begin : g_da
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    da_q[k] <= '0;
      else if (rx_valid && idx == CNT_W'(k))         da_q[k] <= rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      done_q    <= 1'b0;
      typ_q     <= '0;
      blocked_q <= 1'b0;
      da_ok_q   <= 1'b0;
      type_ok_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      pend_q <= trig;
      if (rx_valid) begin
        cnt_q  <= (idx == SAT_IDX) ? idx : idx + 1'b1;
        done_q <= done_eff | trig;
        if (idx == T_HI) typ_q[15:8] <= rx_data;
        if (idx == T_LO) typ_q[7:0]  <= rx_data;
        if (idx == '0)        blocked_q <= 1'b0;
        else if (idx == DA_LAST) blocked_q <= block_now;
      end
      if (trig) begin
        da_ok_q   <= (idx >= DA_LAST);
        type_ok_q <= (idx == LAST_IDX);
      end
    end
  end

  assign da      = da_q;
  assign typ     = typ_q;
  assign da_ok   = da_ok_q;
  assign type_ok = type_ok_q;
  assign blocked = blocked_q;
  assign pend    = pend_q;
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
(
  input  logic [DA_W-1:0]                   da,
  input  logic [15:0]                       typ,
  input  logic                              da_ok,
  input  logic                              type_ok,
  input  logic                              blocked,
  input  filt_cfg_t                         cfg,
  input  logic                              ext,
  input  logic [SA_COUNT-1:0][DA_W-1:0]     sa_val,
  input  logic [SA_COUNT-1:0]               sa_en,
  input  logic [TID_COUNT-1:0][15:0]        tid_val,
  input  logic [TID_COUNT-1:0]              tid_en,
  input  logic [HASH_W-1:0]                 hash_tbl,
  output logic [CODE_COUNT-1:0]             hits,
  output logic                              accept,
  output logic [CODE_W-1:0]                 code
);
  logic [SA_COUNT-1:0]  sa_hit;
  logic [TID_COUNT-1:0] tid_hit;
  logic                 hbit, hash_hit, qual;

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
    assign sa_hit[k] = sa_en[k] && (sa_val[k] == da);
  end
  for (genvar j = 0; j < TID_COUNT; j++) begin : g_tid
    assign tid_hit[j] = tid_en[j] && type_ok && (tid_val[j] == typ);
  end

  assign hbit     = hash_tbl[hash_index(da)];
  assign hash_hit = hbit && (is_group(da) ? cfg.mcast_hash : cfg.ucast_hash);
  assign qual     = da_ok && !blocked;

  always_comb begin
    hits = '0;
    hits[int'(MC_SA0) +: SA_COUNT] = sa_hit;
    hits[MC_TYPE]    = |tid_hit;
    hits[MC_HASH]    = hash_hit;
    hits[MC_EXT]     = ext;
    hits[MC_BCAST]   = is_bcast(da) && !cfg.bcast_reject;
    hits[MC_PROMISC] = cfg.promisc;
  end

  assign accept = qual && (|hits);

  always_comb begin
    code = MC_NONE;
    if (qual) begin
      for (int i = CODE_COUNT - 1; i >= 1; i--) begin
        if (hits[i]) code = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_reject,
  input  logic              cfg_mcast_hash_en,
  input  logic              cfg_ucast_hash_en,
  input  logic              cfg_hdx_rx_en,
  input  logic              stat_half_duplex,
  input  logic              stat_tx_active,
  input  logic              ext_match,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  output logic              dec_valid,
  output logic              frame_accept,
  output logic [CODE_W-1:0] match_code
);
  filt_cfg_t                       cfg;
  logic [SA_COUNT-1:0][DA_W-1:0]   sa_val;
  logic [SA_COUNT-1:0]             sa_en;
  logic [TID_COUNT-1:0][15:0]      tid_val;
  logic [TID_COUNT-1:0]            tid_en;
  logic [HASH_W-1:0]               hash_tbl;
  logic [DA_W-1:0]                 da_w;
  logic [15:0]                     typ_w;
  logic                            da_ok_w, type_ok_w, blocked_w, dec_pend_w, block_now_w;
  logic [CODE_COUNT-1:0]           hits_w;
  logic                            accept_w;
  logic [CODE_W-1:0]               code_w;

  assign cfg         = '{promisc: cfg_promisc, bcast_reject: cfg_bcast_reject,
                         mcast_hash: cfg_mcast_hash_en, ucast_hash: cfg_ucast_hash_en,
                         hdx_rx_en: cfg_hdx_rx_en};
  assign block_now_w = stat_half_duplex && stat_tx_active && !cfg_hdx_rx_en;

  rxf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .sa_val(sa_val), .sa_en(sa_en), .tid_val(tid_val),
    .tid_en(tid_en), .hash_tbl(hash_tbl)
  );

  rxf_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .block_now(block_now_w), .da(da_w),
    .typ(typ_w), .da_ok(da_ok_w), .type_ok(type_ok_w), .blocked(blocked_w),
    .pend(dec_pend_w)
  );

  rxf_match u_match (
    .da(da_w), .typ(typ_w), .da_ok(da_ok_w), .type_ok(type_ok_w),
    .blocked(blocked_w), .cfg(cfg), .ext(ext_match), .sa_val(sa_val),
    .sa_en(sa_en), .tid_val(tid_val), .tid_en(tid_en), .hash_tbl(hash_tbl),
    .hits(hits_w), .accept(accept_w), .code(code_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      frame_accept <= 1'b0;
      match_code   <= '0;
    end else begin
      dec_valid <= dec_pend_w;
      if (dec_pend_w) begin
        frame_accept <= accept_w;
        match_code   <= code_w;
      end
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pend,
  input logic                  blocked,
  input logic                  da_ok,
  input logic                  promisc,
  input logic [CODE_COUNT-1:0] hits,
  input logic                  dec_valid,
  input logic                  frame_accept,
  input logic [CODE_W-1:0]     match_code
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_pend_to_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> dec_valid);

  assert_hdx_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend && blocked |=> !frame_accept && match_code == '0);

  assert_promisc_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend && da_ok && !blocked && promisc |=> frame_accept);

  assert_accept_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (frame_accept == (match_code != '0)));

  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> match_code < CODE_W'(CODE_COUNT));

  assert_first_slot_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && da_ok && !blocked && hits[MC_SA0] |=> match_code == CODE_W'(MC_SA0));

  assert_short_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !da_ok |=> !frame_accept && match_code == '0);
endmodule

bind eth_rx_addr_filter rxf_checker u_rxf_chk (
  .clk(clk), .rst_n(rst_n), .pend(dec_pend_w), .blocked(blocked_w),
  .da_ok(da_ok_w), .promisc(cfg_promisc), .hits(hits_w),
  .dec_valid(dec_valid), .frame_accept(frame_accept), .match_code(match_code)
);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = '0;
  logic cfg_promisc = 0, cfg_bcast_reject = 0, cfg_mcast_hash_en = 0;
  logic cfg_ucast_hash_en = 0, cfg_hdx_rx_en = 0;
  logic stat_half_duplex = 0, stat_tx_active = 0, ext_match = 0;
  logic reg_wr_en = 0;
  logic [3:0] reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic dec_valid, frame_accept;
  logic [3:0] match_code;

  always #2 clk = ~clk;

  eth_rx_addr_filter i_eth_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
    .cfg_mcast_hash_en(cfg_mcast_hash_en), .cfg_ucast_hash_en(cfg_ucast_hash_en),
    .cfg_hdx_rx_en(cfg_hdx_rx_en), .stat_half_duplex(stat_half_duplex),
    .stat_tx_active(stat_tx_active), .ext_match(ext_match), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .dec_valid(dec_valid),
    .frame_accept(frame_accept), .match_code(match_code)
  );

  localparam logic [47:0] SA1 = 48'h5544_3322_1102;
  localparam logic [47:0] SA2 = 48'h7766_5544_3302;
  localparam logic [47:0] SA3 = 48'h6655_4433_2202;
  localparam logic [47:0] SA4 = 48'h8877_6655_4402;
  localparam logic [47:0] UNI = 48'h5544_3322_110A;
  localparam logic [47:0] MC  = 48'h0000_5E00_0001;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  typedef struct packed {
    logic [3:0]  req;
    logic [47:0] da;
    logic [15:0] typ;
    logic [4:0]  cfg;   // {promisc, bcast_reject, mcast_hash, ucast_hash, hdx_rx_en}
    logic        ext;
    logic        txb;
    logic        acc;
    logic [3:0]  code;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd2, SA1, 16'h1234, 5'b00000, 1'b0, 1'b0, 1'b1, 4'd1}, // R2 slot 0
    '{4'd2, SA3, 16'h1234, 5'b00000, 1'b0, 1'b0, 1'b1, 4'd3}, // R2 slot 2
    '{4'd3, UNI, 16'h0800, 5'b00000, 1'b0, 1'b0, 1'b1, 4'd5}, // R3 type hit
    '{4'd4, UNI, 16'h1234, 5'b00010, 1'b0, 1'b0, 1'b1, 4'd6}, // R4 unicast hash
    '{4'd4, UNI, 16'h1234, 5'b00000, 1'b0, 1'b0, 1'b0, 4'd0}, // R4 hash off
    '{4'd5, UNI, 16'h1234, 5'b00000, 1'b1, 1'b0, 1'b1, 4'd7}, // R5 external
    '{4'd6, BC,  16'h1234, 5'b00000, 1'b0, 1'b0, 1'b1, 4'd8}, // R6 broadcast
    '{4'd6, BC,  16'h1234, 5'b01000, 1'b0, 1'b0, 1'b0, 4'd0}, // R6 rejected
    '{4'd6, BC,  16'h1234, 5'b01100, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 reject, hash rescues
    '{4'd7, UNI, 16'h1234, 5'b10000, 1'b0, 1'b0, 1'b1, 4'd9}, // R7 promiscuous
    '{4'd7, BC,  16'h1234, 5'b11000, 1'b0, 1'b0, 1'b1, 4'd9}, // R7 over bcast reject
    '{4'd8, SA1, 16'h1234, 5'b10000, 1'b0, 1'b1, 1'b0, 4'd0}, // R8 blocked
    '{4'd8, SA1, 16'h1234, 5'b00001, 1'b0, 1'b1, 1'b1, 4'd1}, // R8 override
    '{4'd4, MC,  16'h1234, 5'b00010, 1'b0, 1'b0, 1'b0, 4'd0}, // R4 group, unicast en only
    '{4'd4, MC,  16'h1234, 5'b00100, 1'b0, 1'b0, 1'b1, 4'd6}, // R4 group hash
    '{4'd4, UNI, 16'h1234, 5'b00100, 1'b0, 1'b0, 1'b0, 4'd0}, // R4 individual, group en only
    '{4'd2, SA2, 16'h1234, 5'b00000, 1'b0, 1'b0, 1'b0, 4'd0}, // R2 disabled slot
    '{4'd9, SA4, 16'h0800, 5'b00000, 1'b1, 1'b0, 1'b1, 4'd4}, // R9 slot before type/ext
    '{4'd9, SA1, 16'h1234, 5'b10110, 1'b0, 1'b0, 1'b1, 4'd1}  // R9 slot before promisc
  };

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int got_n = 0, got_cyc = 0, mark_cyc = 0;
  logic got_acc = 0;
  logic [3:0] got_code = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (dec_valid) begin
      got_n++;
      got_acc  = frame_accept;
      got_code = match_code;
      got_cyc  = cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] calc_hidx(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int b = 0; b < 48; b++) r[b % 6] ^= a[b];
    return r;
  endfunction

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic set_cfg(input logic [4:0] c);
    {cfg_promisc, cfg_bcast_reject, cfg_mcast_hash_en, cfg_ucast_hash_en, cfg_hdx_rx_en} = c;
  endtask

  // Sends one frame; txm bit k drives half-duplex/transmit status during beat k.
  task automatic send_frame(input logic [47:0] da, input logic [15:0] typ,
                            input int len, input logic [15:0] txm, input logic ext);
    int n0 = got_n;
    ext_match = ext;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      if (i < 6) rx_data = da[8*i +: 8];
      else if (i == 12) rx_data = typ[15:8];
      else if (i == 13) rx_data = typ[7:0];
      else rx_data = 8'(i);
      stat_half_duplex = txm[i];
      stat_tx_active   = txm[i];
      if (i == 13 || (len < 14 && i == len - 1)) mark_cyc = cyc;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    stat_half_duplex = 0; stat_tx_active = 0;
    repeat (3) @(negedge clk);
    ext_match = 0;
    check("R1 one verdict per frame", got_n - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 dec_valid", int'(dec_valid), 0);
    check("R11 accept", int'(frame_accept), 0);
    check("R11 code", int'(match_code), 0);
    rst_n = 1;
    @(negedge clk);
    send_frame(48'h0, 16'h0, 16, 16'h0, 0);
    check("R11 slots disabled accept", int'(got_acc), 0);
    check("R11 slots disabled code", int'(got_code), 0);

    // program registers
    write_reg(4'd0, SA1[31:0]); write_reg(4'd1, {16'h0, SA1[47:32]});
    write_reg(4'd2, SA2[31:0]); write_reg(4'd3, {16'h0, SA2[47:32]});
    write_reg(4'd2, SA2[31:0]); // R2 bottom write disables slot 1
    write_reg(4'd4, SA3[31:0]); write_reg(4'd5, {16'h0, SA3[47:32]});
    write_reg(4'd6, SA4[31:0]); write_reg(4'd7, {16'h0, SA4[47:32]});
    write_reg(4'd9, 32'h8000_0800);
    write_reg(4'd10, 32'h0000_1234); // present but not enabled
    write_reg(4'd12, 32'hFFFF_FFFF); write_reg(4'd13, 32'hFFFF_FFFF);

    for (int v = 0; v < NV; v++) begin
      set_cfg(VECS[v].cfg);
      send_frame(VECS[v].da, VECS[v].typ, 16, VECS[v].txb ? 16'hFFFF : 16'h0, VECS[v].ext);
      check($sformatf("R%0d vec %0d accept", VECS[v].req, v), int'(got_acc), int'(VECS[v].acc));
      check($sformatf("R%0d vec %0d code", VECS[v].req, v), int'(got_code), int'(VECS[v].code));
      if (v == 0) check("R1 latency", got_cyc - mark_cyc, 2);
    end
    set_cfg(5'b0);

    // R4 hash index: one table bit only
    begin
      logic [5:0] hi = calc_hidx(UNI);
      logic [63:0] tbl = 64'h1 << hi;
      write_reg(4'd12, tbl[31:0]); write_reg(4'd13, tbl[63:32]);
      set_cfg(5'b00010);
      send_frame(UNI, 16'h1234, 16, 16'h0, 0);
      check("R4 indexed bit code", int'(got_code), 6);
      tbl = 64'h1 << (hi ^ 6'd1);
      write_reg(4'd12, tbl[31:0]); write_reg(4'd13, tbl[63:32]);
      send_frame(UNI, 16'h1234, 16, 16'h0, 0);
      check("R4 neighbour bit code", int'(got_code), 0);
      set_cfg(5'b0);
    end

    // R10 short frames
    set_cfg(5'b10000);
    send_frame(SA1, 16'h0, 4, 16'h0, 0);
    check("R10 4-byte accept", int'(got_acc), 0);
    check("R10 4-byte code", int'(got_code), 0);
    check("R10 eof latency", got_cyc - mark_cyc, 2);
    set_cfg(5'b0);
    send_frame(SA1, 16'h0, 8, 16'h0, 0);
    check("R10 8-byte slot hit", int'(got_code), 1);
    send_frame(UNI, 16'h0, 13, 16'h0, 0);
    check("R10 13-byte no type compare", int'(got_code), 0);

    // R8 sampling beat
    send_frame(SA1, 16'h1234, 16, 16'b1111_1111_1100_0000, 0);
    check("R8 tx after byte 5 ignored", int'(got_code), 1);
    send_frame(SA1, 16'h1234, 16, 16'b0000_0000_0010_0000, 0);
    check("R8 tx on byte 5 blocks", int'(got_acc), 0);

    // R2 bottom rewrite disables, top rewrite enables
    write_reg(4'd0, SA1[31:0]);
    send_frame(SA1, 16'h1234, 16, 16'h0, 0);
    check("R2 disabled after bottom write", int'(got_acc), 0);
    write_reg(4'd1, {16'h0, SA1[47:32]});
    send_frame(SA1, 16'h1234, 16, 16'h0, 0);
    check("R2 enabled after top write", int'(got_code), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule